// File: doc/BRIEF.md
# Serial Control Register File with Event Interrupt

This block is the slave end of a slow serial control bus. The host selects it with an active-low select line and clocks 8-bit words in both directions. The clock idles high. The host changes its data after a rising clock edge, and both sides capture on the falling edge. The most significant bit travels first. The first word of a frame is a command: bit 6 chooses read (1) or write (0), bits 5..2 give a register address, and bits 7 and 1..0 carry no meaning. The words that follow carry data. A write stores the first data word into the addressed register. A read returns the addressed register in the first data word. A read of the motion address returns a three-word burst while the host clocks zeros.

Detection logic outside the block raises single-cycle event pulses for click, movement, transit, slice and read error. Each pulse sets a sticky status bit. The active-low interrupt output is driven low while any status bit has its enable set. The host reads the status register, and that read clears the bits it reported. Motion deltas arrive on a valid/ready stream and are summed with saturation into two signed 8-bit totals. The stream applies back-pressure (ready low) from the moment a motion burst is decoded until that burst completes or is abandoned, so the reported totals cannot move underneath the host. Mode and interrupt-enable values are driven out as plain ports.

Top module: `ctrl_spi_regs`

## Requirements
- R1: Serial format: clock idle high, MOSI captured on falling SCK edges, MSB first, 8-bit words. MISO presents each bit before the falling edge on which it is taken, and stays 0 while select is high and during the command word.
- R2: After reset: mode = 7'b0000100, interrupt enable = 0, status = 0, irq_n = 1, motion totals and click flag = 0, mot_ready = 1.
- R3: Address 1 is the mode register. Command 0x84 writes it from data bits 6..0, and data bit 7 is ignored. Command 0xC4 reads it back as {0, mode}.
- R4: Address 2 is the interrupt-enable register. Command 0x88 writes data bits 6..2: b6 click, b5 movement, b4 transit, b3 slice, b2 read error. Command 0xC8 reads it with bits 7, 1 and 0 as 0.
- R5: Each event pulse sets its sticky status bit: b7 click, b6 movement, b5 transit, b4 slice, b3 read error. Bits 2..0 read 0.
- R6: irq_n is low exactly when some status bit and its matching enable bit are both 1, one clock after the status change.
- R7: A status read (command 0xC0) returns the status byte. Once that data word completes, the bits it reported are cleared. An event arriving in the clearing cycle is kept.
- R8: Command 0xE0 (address 8) returns three words. Word 1 is a header: b0 click since last burst, b3 always 1, b4 X sign, b5 Y sign, other bits 0. Word 2 is total X and word 3 is total Y, both two's complement. Completing the third word clears the totals and the reported click flag.
- R9: A motion sample is taken when mot_valid and mot_ready are both high. Each delta is added with saturation at +127 and -128. mot_ready is low from decode of a motion burst until that burst completes or select rises.
- R10: Writes to the status address (0) or the motion address (8) change nothing. A read of any unmapped address returns 0x00.
- R11: If select rises before a word completes, that word has no effect. A motion burst left before its third word leaves the totals uncleared.
- R12: Data words after the first in a write are ignored. Read words beyond the defined ones return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host, idle high |
| spi_ss_n | input | 1 | Active-low select from the host |
| spi_mosi | input | 1 | Host-to-block serial data |
| spi_miso | output | 1 | Block-to-host serial data |
| evt_click | input | 1 | Click event pulse |
| evt_move | input | 1 | Movement event pulse |
| evt_transit | input | 1 | Transit event pulse |
| evt_slice | input | 1 | Slice event pulse |
| evt_readerr | input | 1 | Read-error event pulse |
| mot_valid | input | 1 | Motion sample valid |
| mot_ready | output | 1 | Motion sample accepted when high |
| mot_dx | input | 8 | Signed X delta |
| mot_dy | input | 8 | Signed Y delta |
| mode_ctrl | output | 7 | Current mode register |
| irq_enable | output | 5 | Current enables, click..read error |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with the default two synchronizer stages. It drives the serial clock with an 8-cycle half period, so the three-cycle path from a pin edge to a captured word fits well inside each half period. That leaves room to raise select at any bit position, which reaches the abort cases. Two same-sign deltas of 100 take both 8-bit totals to their saturation limits. A burst held open lets the bench check the stream's back-pressure and confirm that a refused sample is lost.

// File: rtl/csr_spi_pkg.sv
package csr_spi_pkg;
  localparam int BYTE_W       = 8;
  localparam int ADDR_W       = 4;
  localparam int EVT_N        = 5;
  localparam int MODE_W       = 7;
  localparam int CMD_RW_BIT   = 6;
  localparam int CMD_ADDR_LSB = 2;
  localparam int STATUS_LSB   = BYTE_W - EVT_N;
  localparam int IRQEN_LSB    = 2;
  localparam int MOT_WORDS    = 3;

  localparam logic [ADDR_W-1:0] A_STATUS = 4'd0;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd1;
  localparam logic [ADDR_W-1:0] A_IRQEN  = 4'd2;
  localparam logic [ADDR_W-1:0] A_MOTION = 4'd8;

  localparam logic [MODE_W-1:0] MODE_RST = 7'b0000100;

  typedef enum logic {PH_CMD, PH_DATA} phase_e;
endpackage

// File: rtl/csr_spi_frontend.sv
module csr_spi_frontend #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              ss_n,
  input  logic              mosi,
  input  logic              tx_load,
  input  logic [WORD_W-1:0] tx_word,
  output logic              active,
  output logic              byte_done,
  output logic [WORD_W-1:0] rx_word,
  output logic              miso
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [SYNC_STAGES-1:0] sck_sr, ss_sr, mosi_sr;
  logic sck_s, ss_s, mosi_s, sck_prev, sck_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic [WORD_W-1:0] rx_sr, tx_sr;

  // pin synchronizers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sr   <= '1;
      ss_sr    <= '1;
      mosi_sr  <= '0;
      sck_prev <= 1'b1;
    end else begin
      sck_sr   <= {sck_sr[SYNC_STAGES-2:0], sck};
      ss_sr    <= {ss_sr[SYNC_STAGES-2:0], ss_n};
      mosi_sr  <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      sck_prev <= sck_s;
    end
  end

  assign sck_s    = sck_sr[SYNC_STAGES-1];
  assign ss_s     = ss_sr[SYNC_STAGES-1];
  assign mosi_s   = mosi_sr[SYNC_STAGES-1];
  assign active   = ~ss_s;
  assign sck_fall = active & sck_prev & ~sck_s;

  // receive side: capture on falling edges, word strobe one clock later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      rx_word   <= '0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        bit_cnt <= '0;
        rx_sr   <= '0;
      end else if (sck_fall) begin
        rx_sr   <= {rx_sr[WORD_W-2:0], mosi_s};
        bit_cnt <= (bit_cnt == LAST_BIT) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST_BIT) begin
          byte_done <= 1'b1;
          rx_word   <= {rx_sr[WORD_W-2:0], mosi_s};
        end
      end
    end
  end

  // transmit side: next bit appears after the edge the host sampled on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sr <= '0;
    end else if (!active) begin
      tx_sr <= '0;
    end else if (tx_load) begin
      tx_sr <= tx_word;
    end else if (sck_fall) begin
      tx_sr <= {tx_sr[WORD_W-2:0], 1'b0};
    end
  end

  assign miso = active & tx_sr[WORD_W-1];

  // R1: a completed word always leaves the bit counter at its start
  p_word_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> (bit_cnt == '0));
endmodule

// File: rtl/csr_event_regs.sv
module csr_event_regs
  import csr_spi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVT_N-1:0]  evt,
  input  logic              clr_en,
  input  logic [EVT_N-1:0]  clr_mask,
  input  logic              wr_mode,
  input  logic              wr_irqen,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [MODE_W-1:0] mode_q,
  output logic [EVT_N-1:0]  irqen_q,
  output logic [EVT_N-1:0]  status_q,
  output logic              irq_n
);
  logic [EVT_N-1:0] clr_vec;
  logic             data_msb_unused;

  assign data_msb_unused = wr_data[BYTE_W-1];

  always_comb begin
    clr_vec = clr_en ? clr_mask : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_RST;
      irqen_q  <= '0;
      status_q <= '0;
      irq_n    <= 1'b1;
    end else begin
      status_q <= (status_q & ~clr_vec) | evt;
      if (wr_mode)  mode_q  <= wr_data[MODE_W-1:0];
      if (wr_irqen) irqen_q <= wr_data[IRQEN_LSB +: EVT_N];
      irq_n <= ~|(status_q & irqen_q);
    end
  end

  // R5: status bits hold unless a clear is in progress
  p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_en |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R5: every pulsed event is visible on the next cycle
  p_event_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/csr_motion_acc.sv
module csr_motion_acc
  import csr_spi_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [BYTE_W-1:0] dx,
  input  logic signed [BYTE_W-1:0] dy,
  input  logic                     hold,
  input  logic                     snap,
  input  logic                     clear,
  input  logic                     click_evt,
  output logic signed [BYTE_W-1:0] acc_x,
  output logic signed [BYTE_W-1:0] acc_y,
  output logic                     click_q
);
  localparam logic signed [BYTE_W-1:0] S_MAX = {1'b0, {(BYTE_W-1){1'b1}}};
  localparam logic signed [BYTE_W-1:0] S_MIN = {1'b1, {(BYTE_W-1){1'b0}}};

  logic take, click_snap;

  function automatic logic signed [BYTE_W-1:0] sat_add(
    input logic signed [BYTE_W-1:0] a,
    input logic signed [BYTE_W-1:0] b
  );
    logic signed [BYTE_W:0] s;
    s = {a[BYTE_W-1], a} + {b[BYTE_W-1], b};
    if (s[BYTE_W] != s[BYTE_W-1]) return s[BYTE_W] ? S_MIN : S_MAX;
    return s[BYTE_W-1:0];
  endfunction

  assign in_ready = ~hold;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_x      <= '0;
      acc_y      <= '0;
      click_q    <= 1'b0;
      click_snap <= 1'b0;
    end else begin
      if (snap) click_snap <= click_q;
      if (clear) begin
        acc_x   <= '0;
        acc_y   <= '0;
        click_q <= (click_q & ~click_snap) | click_evt;
      end else begin
        click_q <= click_q | click_evt;
        if (take) begin
          acc_x <= sat_add(acc_x, dx);
          acc_y <= sat_add(acc_y, dy);
        end
      end
    end
  end

  // R9: a non-negative delta never lowers the X total (no wrap)
  p_x_no_wrap_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !dx[BYTE_W-1] && !clear) |=> (acc_x >= $past(acc_x)));

  // R9: a negative delta never raises the Y total
  p_y_no_wrap_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dy[BYTE_W-1] && !clear) |=> (acc_y <= $past(acc_y)));
endmodule

// File: rtl/ctrl_spi_regs.sv
module ctrl_spi_regs
  import csr_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_ss_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              evt_click,
  input  logic              evt_move,
  input  logic              evt_transit,
  input  logic              evt_slice,
  input  logic              evt_readerr,
  input  logic              mot_valid,
  output logic              mot_ready,
  input  logic [BYTE_W-1:0] mot_dx,
  input  logic [BYTE_W-1:0] mot_dy,
  output logic [MODE_W-1:0] mode_ctrl,
  output logic [EVT_N-1:0]  irq_enable,
  output logic              irq_n
);
  localparam logic [1:0] LAST_MOT = 2'(MOT_WORDS - 1);

  logic              active, byte_done, tx_load;
  logic [BYTE_W-1:0] rx_word, tx_word, mot_hdr;
  logic              cmd_rd, cmd_done, data_done, nav_start, nav_clear, hold;
  logic [ADDR_W-1:0] cmd_addr;
  logic              wr_mode, wr_irqen, clr_en;
  logic [EVT_N-1:0]  status_q, status_snap, evt_vec;
  logic signed [BYTE_W-1:0] acc_x, acc_y;
  logic              click_q;
  logic              cmd_bits_unused;

  phase_e     ph;
  logic       is_read, nav_busy;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0] didx;

  csr_spi_frontend #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(BYTE_W)) u_front (
    .clk(clk), .rst_n(rst_n), .sck(spi_sck), .ss_n(spi_ss_n), .mosi(spi_mosi),
    .tx_load(tx_load), .tx_word(tx_word), .active(active),
    .byte_done(byte_done), .rx_word(rx_word), .miso(spi_miso)
  );

  assign cmd_rd          = rx_word[CMD_RW_BIT];
  assign cmd_addr        = rx_word[CMD_ADDR_LSB +: ADDR_W];
  assign cmd_bits_unused = ^{rx_word[BYTE_W-1], rx_word[CMD_ADDR_LSB-1:0]};
  assign cmd_done        = byte_done & active & (ph == PH_CMD);
  assign data_done       = byte_done & active & (ph == PH_DATA);
  assign nav_start       = cmd_done & cmd_rd & (cmd_addr == A_MOTION);
  assign hold            = nav_busy | nav_start;

  assign wr_mode   = data_done & ~is_read & (didx == 2'd0) & (addr_q == A_MODE);
  assign wr_irqen  = data_done & ~is_read & (didx == 2'd0) & (addr_q == A_IRQEN);
  assign clr_en    = data_done &  is_read & (didx == 2'd0) & (addr_q == A_STATUS);
  assign nav_clear = data_done &  is_read & (didx == LAST_MOT) & (addr_q == A_MOTION);

  assign mot_hdr = {2'b00, acc_y[BYTE_W-1], acc_x[BYTE_W-1], 1'b1, 2'b00, click_q};

  // word to present next on MISO
  always_comb begin
    tx_load = 1'b0;
    tx_word = '0;
    if (cmd_done && cmd_rd) begin
      tx_load = 1'b1;
      case (cmd_addr)
        A_STATUS: tx_word = {status_q, {STATUS_LSB{1'b0}}};
        A_MODE:   tx_word = {1'b0, mode_ctrl};
        A_IRQEN:  tx_word = {1'b0, irq_enable, {IRQEN_LSB{1'b0}}};
        A_MOTION: tx_word = mot_hdr;
        default:  tx_word = '0;
      endcase
    end else if (data_done && is_read && addr_q == A_MOTION && didx < LAST_MOT) begin
      tx_load = 1'b1;
      tx_word = (didx == 2'd0) ? acc_x : acc_y;
    end
  end

  // transaction sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= PH_CMD;
      is_read     <= 1'b0;
      addr_q      <= '0;
      didx        <= '0;
      nav_busy    <= 1'b0;
      status_snap <= '0;
    end else if (!active) begin
      ph       <= PH_CMD;
      didx     <= '0;
      nav_busy <= 1'b0;
    end else if (cmd_done) begin
      ph      <= PH_DATA;
      is_read <= cmd_rd;
      addr_q  <= cmd_addr;
      didx    <= '0;
      if (nav_start) nav_busy <= 1'b1;
      if (cmd_rd && cmd_addr == A_STATUS) status_snap <= status_q;
    end else if (data_done) begin
      if (didx != 2'd3) didx <= didx + 2'd1;
      if (nav_clear) nav_busy <= 1'b0;
    end
  end

  assign evt_vec = {evt_click, evt_move, evt_transit, evt_slice, evt_readerr};

  csr_event_regs u_regs (
    .clk(clk), .rst_n(rst_n), .evt(evt_vec), .clr_en(clr_en), .clr_mask(status_snap),
    .wr_mode(wr_mode), .wr_irqen(wr_irqen), .wr_data(rx_word),
    .mode_q(mode_ctrl), .irqen_q(irq_enable), .status_q(status_q), .irq_n(irq_n)
  );

  csr_motion_acc u_motion (
    .clk(clk), .rst_n(rst_n), .in_valid(mot_valid), .in_ready(mot_ready),
    .dx(mot_dx), .dy(mot_dy), .hold(hold), .snap(nav_start), .clear(nav_clear),
    .click_evt(evt_click), .acc_x(acc_x), .acc_y(acc_y), .click_q(click_q)
  );

  // R11: configuration only moves on a completed word
  p_mode_needs_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(mode_ctrl));
  p_irqen_needs_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_done |=> $stable(irq_enable));
  // R9: an open motion burst back-pressures the stream
  p_busy_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nav_busy |-> !mot_ready);
endmodule

// File: tb/test_ctrl_spi_regs.sv
module test_ctrl_spi_regs;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk, rst_n, spi_sck, spi_ss_n, spi_mosi, spi_miso;
  logic evt_click, evt_move, evt_transit, evt_slice, evt_readerr;
  logic mot_valid, mot_ready;
  logic [7:0] mot_dx, mot_dy;
  logic [6:0] mode_ctrl;
  logic [4:0] irq_enable;
  logic irq_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit settled = 0;

  // behavioural reference state
  logic [7:0] m_status, m_mode, m_en;
  int m_x, m_y;
  bit m_click;

  logic [7:0] txb [4];
  logic [7:0] rxb [4];
  logic [7:0] r;

  ctrl_spi_regs i_ctrl_spi_regs (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_ss_n(spi_ss_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .evt_click(evt_click),
    .evt_move(evt_move), .evt_transit(evt_transit), .evt_slice(evt_slice),
    .evt_readerr(evt_readerr), .mot_valid(mot_valid), .mot_ready(mot_ready),
    .mot_dx(mot_dx), .mot_dy(mot_dy), .mode_ctrl(mode_ctrl),
    .irq_enable(irq_enable), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int clamp8(input int v);
    if (v > 127) return 127;
    if (v < -128) return -128;
    return v;
  endfunction

  function automatic logic [7:0] exp_hdr();
    return 8'h08 | {7'b0, m_click} | ((m_x < 0) ? 8'h10 : 8'h00) | ((m_y < 0) ? 8'h20 : 8'h00);
  endfunction

  // per-clock comparison against the reference while the bus is quiet
  always @(negedge clk) begin
    if (settled && rst_n && !done) begin
      chk(mode_ctrl == m_mode[6:0], "R3 mode", 32'(mode_ctrl), 32'(m_mode[6:0]));
      chk(irq_enable == m_en[6:2], "R4 enable", 32'(irq_enable), 32'(m_en[6:2]));
      chk(irq_n == !(|(m_status[7:3] & m_en[6:2])), "R6 irq_n", 32'(irq_n),
          32'(!(|(m_status[7:3] & m_en[6:2]))));
      chk(mot_ready == 1'b1, "R9 ready idle", 32'(mot_ready), 32'd1);
    end
  end

  task automatic spi_byte(input logic [7:0] tb_in, output logic [7:0] rb);
    for (int i = 7; i >= 0; i--) begin
      spi_mosi = tb_in[i];
      repeat (HALF) @(negedge clk);
      rb[i] = spi_miso;
      spi_sck = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
    end
  endtask

  task automatic spi_txn(input int n, input bit close);
    settled = 0;
    @(negedge clk);
    spi_ss_n = 1'b0;
    for (int k = 0; k < n; k++) spi_byte(txb[k], rxb[k]);
    if (close) begin
      repeat (HALF) @(negedge clk);
      spi_ss_n = 1'b1;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic spi_abort(input logic [7:0] tb_in, input int nbits);
    settled = 0;
    spi_ss_n = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tb_in[i];
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
    end
    repeat (HALF) @(negedge clk);
    spi_ss_n = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
    settled = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic xfer2(input logic [7:0] cmd, input logic [7:0] dat, output logic [7:0] rd);
    txb[0] = cmd; txb[1] = dat;
    spi_txn(2, 1);
    rd = rxb[1];
  endtask

  task automatic pulse_evt(input logic [4:0] v);
    settled = 0;
    @(negedge clk);
    {evt_click, evt_move, evt_transit, evt_slice, evt_readerr} = v;
    @(negedge clk);
    {evt_click, evt_move, evt_transit, evt_slice, evt_readerr} = '0;
    m_status = m_status | {v, 3'b000};
    if (v[4]) m_click = 1;
    settle();
  endtask

  task automatic push_mot(input int dx, input int dy, input bit expect_ready);
    bit took;
    @(negedge clk);
    mot_valid = 1'b1; mot_dx = dx[7:0]; mot_dy = dy[7:0];
    #1;
    took = mot_ready;
    chk(mot_ready == expect_ready, "R9 ready", 32'(mot_ready), 32'(expect_ready));
    @(negedge clk);
    mot_valid = 1'b0;
    if (took) begin
      m_x = clamp8(m_x + dx);
      m_y = clamp8(m_y + dy);
    end
  endtask

  task automatic read_motion(input string tag);
    logic [7:0] eh;
    eh = exp_hdr();
    txb[0] = 8'hE0; txb[1] = 8'h00; txb[2] = 8'h00; txb[3] = 8'h00;
    spi_txn(4, 1);
    chk(rxb[1] == eh, tag, 32'(rxb[1]), 32'(eh));
    chk(rxb[2] == m_x[7:0], tag, 32'(rxb[2]), 32'(m_x[7:0]));
    chk(rxb[3] == m_y[7:0], tag, 32'(rxb[3]), 32'(m_y[7:0]));
    m_x = 0; m_y = 0; m_click = 0;
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; spi_sck = 1'b1; spi_ss_n = 1'b1; spi_mosi = 1'b0;
    {evt_click, evt_move, evt_transit, evt_slice, evt_readerr} = '0;
    mot_valid = 1'b0; mot_dx = '0; mot_dy = '0;
    m_status = 8'h00; m_mode = 8'h04; m_en = 8'h00; m_x = 0; m_y = 0; m_click = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 reset state
    chk(mode_ctrl == 7'h04, "R2 mode", 32'(mode_ctrl), 32'h04);
    chk(irq_enable == 5'h00, "R2 enable", 32'(irq_enable), 32'h0);
    chk(irq_n == 1'b1, "R2 irq_n", 32'(irq_n), 32'h1);
    chk(spi_miso == 1'b0, "R2 R1 miso idle", 32'(spi_miso), 32'h0);
    chk(mot_ready == 1'b1, "R2 ready", 32'(mot_ready), 32'h1);
    settled = 1;

    // R1 R3 read of reset mode
    xfer2(8'hC4, 8'h00, r); chk(r == 8'h04, "R1 R3 read mode", 32'(r), 32'h04); settle();
    // R3 write with bit 7 set
    xfer2(8'h84, 8'hB1, r); m_mode = 8'h31; settle();
    xfer2(8'hC4, 8'h00, r); chk(r == 8'h31, "R3 readback", 32'(r), 32'h31); settle();
    // R4 enable register
    xfer2(8'h88, 8'hFF, r); m_en = 8'h7C; settle();
    xfer2(8'hC8, 8'h00, r); chk(r == 8'h7C, "R4 readback", 32'(r), 32'h7C); settle();
    xfer2(8'h88, 8'h00, r); m_en = 8'h00; settle();

    // R5 R6 R7 masked event, then read-to-clear
    pulse_evt(5'b10000);
    chk(irq_n == 1'b1, "R6 masked", 32'(irq_n), 32'h1);
    xfer2(8'hC0, 8'h00, r); chk(r == 8'h80, "R5 R7 status", 32'(r), 32'h80); m_status = 0; settle();
    xfer2(8'hC0, 8'h00, r); chk(r == 8'h00, "R7 cleared", 32'(r), 32'h00); settle();

    // R6 enabled movement raises irq, status read releases it
    xfer2(8'h88, 8'h20, r); m_en = 8'h20; settle();
    pulse_evt(5'b01000);
    chk(irq_n == 1'b0, "R6 asserted", 32'(irq_n), 32'h0);
    pulse_evt(5'b00001);
    xfer2(8'hC0, 8'h00, r); chk(r == 8'h48, "R5 R7 two bits", 32'(r), 32'h48); m_status = 0; settle();
    chk(irq_n == 1'b1, "R7 R6 released", 32'(irq_n), 32'h1);

    // R10 read-only and unmapped
    pulse_evt(5'b00010);
    xfer2(8'h80, 8'hFF, r); settle();
    xfer2(8'hC0, 8'h00, r); chk(r == 8'h10, "R10 status write ignored", 32'(r), 32'h10); m_status = 0; settle();
    xfer2(8'hD4, 8'h00, r); chk(r == 8'h00, "R10 unmapped", 32'(r), 32'h00); settle();
    xfer2(8'hA0, 8'h7F, r); settle();

    // R11 aborts in data and command words
    txb[0] = 8'h84; spi_txn(1, 0); spi_abort(8'h7F, 4); settle();
    spi_abort(8'h84, 5); settle();
    xfer2(8'hC4, 8'h00, r); chk(r == 8'h31, "R11 abort no write", 32'(r), 32'h31); settle();

    // R8 R9 motion with saturation
    push_mot(5, -3, 1); push_mot(100, -100, 1); push_mot(100, -100, 1);
    pulse_evt(5'b10000);
    read_motion("R8 R9 burst");
    read_motion("R8 cleared");
    xfer2(8'hC0, 8'h00, r); chk(r == 8'h80, "R5 click status", 32'(r), 32'h80); m_status = 0; settle();

    // R9 R11 back-pressure and abandoned burst
    push_mot(-2, 9, 1);
    txb[0] = 8'hE0; txb[1] = 8'h00; spi_txn(2, 0);
    chk(rxb[1] == exp_hdr(), "R8 header sign", 32'(rxb[1]), 32'(exp_hdr()));
    chk(mot_ready == 1'b0, "R9 busy", 32'(mot_ready), 32'h0);
    push_mot(7, 7, 0);
    spi_abort(8'h00, 3); settle();
    read_motion("R11 R9 kept");

    // R12 extra words
    txb[0] = 8'h84; txb[1] = 8'h12; txb[2] = 8'h55; spi_txn(3, 1); m_mode = 8'h12; settle();
    txb[0] = 8'hC4; txb[1] = 8'h00; txb[2] = 8'h00; spi_txn(3, 1);
    chk(rxb[1] == 8'h12, "R12 first word", 32'(rxb[1]), 32'h12);
    chk(rxb[2] == 8'h00, "R12 trailing zero", 32'(rxb[2]), 32'h00);
    settle();

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule